// File: doc/BRIEF.md
# Overlay Color Lookup Pixel Path

This block turns one pixel index per clock into a 24-bit colour word. Normally the index addresses a 256-entry colour table and the stored word is sent out. A 5-bit overlay code, sampled with every pixel, can replace the pixel. Each valid code points straight at one of 30 table slots held back at the top of the table for overlay colours. A bypass pin can send the raw pixel value around the table, but only when a format-control enable bit allows it.

A host loads table entries through a simple write port with a write enable, an address and data. Every path takes exactly one clock from input to `colour_o`: the table path, the overlay path and the bypass path. Downstream logic therefore sees a fixed pipeline.

Top module: `clut_pix_path`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released with no clock edge yet, `colour_o` reads zero.
- R2: With overlay code 0 and bypass not in effect, `colour_o` after the next rising edge equals the table entry at `pix_idx_i`.
- R3: Overlay codes 1 to 30 select table address 225 + code, which covers addresses 226 to 255. The pixel index has no effect on this.
- R4: Overlay code 0 and overlay code 31 both mean no overlay, and the pixel path is used.
- R5: When `fmt_bypass_en_i` is 1, `clut_keep_i` is 0 and no overlay is valid, `colour_o` is the pixel value copied onto all three channels. The channels are red in bits 23:16, green in 15:8 and blue in 7:0.
- R6: When `fmt_bypass_en_i` is 0, `clut_keep_i` has no effect and the table is always used.
- R7: When `fmt_bypass_en_i` is 1 and `clut_keep_i` is 1, the table is used.
- R8: A valid overlay code wins over bypass. Its overlay table entry is output even while bypass conditions hold.
- R9: A host write with `wr_en_i` = 1 stores `wr_data_i` at `wr_addr_i`, and later reads of that address return it.
- R10: A write to the address being read in the same cycle shows the new data on `colour_o` after that same rising edge.
- R11: Every path has one clock of latency. Inputs applied before an edge change `colour_o` only at that edge, and the output then holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pix_idx_i | input | 8 | Pixel index |
| ovl_code_i | input | 5 | Overlay code; 0 or codes above 30 mean none |
| clut_keep_i | input | 1 | High keeps the table in the path; low requests bypass |
| fmt_bypass_en_i | input | 1 | Enable bit that lets `clut_keep_i` take effect |
| wr_en_i | input | 1 | Host table write enable |
| wr_addr_i | input | 8 | Host table write address |
| wr_data_i | input | 24 | Host table write data |
| colour_o | output | 24 | Colour word, red 23:16, green 15:8, blue 7:0 |

## Verification
The bench builds the block with 8-bit indices, a 5-bit overlay code, 30 overlay slots, three 8-bit channels and write-through enabled. With these values the top overlay slot at address 255 can be reached, and so can the first code past the reserved range, 31. Because the channel width equals the index width, every bypass output can be compared bit for bit with the pixel. The bench also fills all 256 entries with a pattern whose green byte never equals the index, so a bypass result can never be mistaken for a table result.

// File: rtl/clut_pkg.sv
package clut_pkg;

   // Source that feeds the output stage in a given cycle
   typedef enum logic {
      SRC_TABLE  = 1'b0,
      SRC_BYPASS = 1'b1
   } clut_src_e;

   // Number of bits needed to hold a value in [0, n]
   function automatic int unsigned bits_for(input int unsigned n);
      int unsigned b;
      b = 1;
      while ((1 << b) <= n) b++;
      return b;
   endfunction

endpackage

// File: rtl/clut_sel.sv
module clut_sel
   import clut_pkg::*;
#(
   parameter int unsigned IDX_W     = 8,
   parameter int unsigned OVL_W     = 5,
   parameter int unsigned OVL_COUNT = 30
) (
   input  logic [IDX_W-1:0] pix_idx_i,
   input  logic [OVL_W-1:0] ovl_code_i,
   input  logic             keep_i,
   input  logic             byp_en_i,
   output logic [IDX_W-1:0] rd_addr_o,
   output clut_src_e        src_o,
   output logic             ovl_hit_o
);

   localparam int unsigned DEPTH    = 1 << IDX_W;
   localparam int unsigned OVL_BASE = DEPTH - OVL_COUNT;

   logic             hit;
   logic [IDX_W-1:0] ovl_addr;

   generate
      if (OVL_COUNT == 0) begin : g_no_ovl
         assign hit      = 1'b0;
         assign ovl_addr = '0;
      end else begin : g_ovl
         logic [OVL_W-1:0] code_off;
         assign hit      = (ovl_code_i != '0) &&
                           (ovl_code_i <= OVL_W'(OVL_COUNT));
         assign code_off = ovl_code_i - OVL_W'(1);
         assign ovl_addr = IDX_W'(OVL_BASE) + IDX_W'(code_off);
      end
   endgenerate

   always_comb begin
      rd_addr_o = hit ? ovl_addr : pix_idx_i;
      if (!hit && byp_en_i && !keep_i) src_o = SRC_BYPASS;
      else                             src_o = SRC_TABLE;
   end

   assign ovl_hit_o = hit;

endmodule

// File: rtl/clut_ram.sv
module clut_ram #(
   parameter int unsigned AW            = 8,
   parameter int unsigned DW            = 24,
   parameter bit          WRITE_THROUGH = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          we_i,
   input  logic [AW-1:0] wa_i,
   input  logic [DW-1:0] wd_i,
   input  logic [AW-1:0] ra_i,
   output logic [DW-1:0] rd_o
);

   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] rd_q;
   logic [DW-1:0] rd_next;

   always_ff @(posedge clk_i) begin
      if (we_i) mem[wa_i] <= wd_i;
   end

   generate
      if (WRITE_THROUGH) begin : g_wt
         always_comb begin
            if (we_i && (wa_i == ra_i)) rd_next = wd_i;
            else                        rd_next = mem[ra_i];
         end
      end else begin : g_rf
         always_comb rd_next = mem[ra_i];
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) rd_q <= '0;
      else         rd_q <= rd_next;
   end

   assign rd_o = rd_q;

endmodule

// File: rtl/clut_out.sv
module clut_out
   import clut_pkg::*;
#(
   parameter int unsigned IDX_W = 8,
   parameter int unsigned CH_W  = 8,
   parameter int unsigned NCH   = 3
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  clut_src_e           src_i,
   input  logic [IDX_W-1:0]    pix_idx_i,
   input  logic [CH_W*NCH-1:0] tab_i,
   output logic [CH_W*NCH-1:0] colour_o
);

   localparam int unsigned COL_W = CH_W * NCH;

   clut_src_e        src_q;
   logic [IDX_W-1:0] pix_q;
   logic [CH_W-1:0]  chan;
   logic [COL_W-1:0] rep;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         src_q <= SRC_TABLE;
         pix_q <= '0;
      end else begin
         src_q <= src_i;
         pix_q <= pix_idx_i;
      end
   end

   generate
      if (CH_W == IDX_W) begin : g_same
         assign chan = pix_q;
      end else begin : g_pad
         assign chan = {pix_q, {(CH_W-IDX_W){1'b0}}};
      end
      for (genvar g = 0; g < NCH; g++) begin : g_rep
         assign rep[g*CH_W +: CH_W] = chan;
      end
   endgenerate

   assign colour_o = (src_q == SRC_BYPASS) ? rep : tab_i;

endmodule

// File: rtl/clut_pix_path.sv
module clut_pix_path
   import clut_pkg::*;
#(
   parameter int unsigned IDX_W         = 8,
   parameter int unsigned OVL_W         = 5,
   parameter int unsigned OVL_COUNT     = 30,
   parameter int unsigned CH_W          = 8,
   parameter int unsigned NCH           = 3,
   parameter bit          WRITE_THROUGH = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [IDX_W-1:0]    pix_idx_i,
   input  logic [OVL_W-1:0]    ovl_code_i,
   input  logic                clut_keep_i,
   input  logic                fmt_bypass_en_i,
   input  logic                wr_en_i,
   input  logic [IDX_W-1:0]    wr_addr_i,
   input  logic [CH_W*NCH-1:0] wr_data_i,
   output logic [CH_W*NCH-1:0] colour_o
);

   localparam int unsigned DEPTH = 1 << IDX_W;
   localparam int unsigned COL_W = CH_W * NCH;
   localparam int unsigned CODE_BITS = bits_for(OVL_COUNT);

   generate
      if (OVL_COUNT >= DEPTH) begin : g_chk_depth
         $error("overlay slots must leave room for pixel entries");
      end
      if (CODE_BITS > OVL_W) begin : g_chk_code
         $error("overlay code too narrow for slot count");
      end
      if (CH_W < IDX_W) begin : g_chk_chan
         $error("channel narrower than pixel index");
      end
      if (NCH == 0) begin : g_chk_nch
         $error("at least one colour channel required");
      end
   endgenerate

   logic [IDX_W-1:0] rd_addr;
   clut_src_e        src_sel;
   logic             ovl_hit;
   logic [COL_W-1:0] tab_rd;

   clut_sel #(
      .IDX_W    (IDX_W),
      .OVL_W    (OVL_W),
      .OVL_COUNT(OVL_COUNT)
   ) i_sel (
      .pix_idx_i (pix_idx_i),
      .ovl_code_i(ovl_code_i),
      .keep_i    (clut_keep_i),
      .byp_en_i  (fmt_bypass_en_i),
      .rd_addr_o (rd_addr),
      .src_o     (src_sel),
      .ovl_hit_o (ovl_hit)
   );

   clut_ram #(
      .AW           (IDX_W),
      .DW           (COL_W),
      .WRITE_THROUGH(WRITE_THROUGH)
   ) i_ram (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (wr_en_i),
      .wa_i  (wr_addr_i),
      .wd_i  (wr_data_i),
      .ra_i  (rd_addr),
      .rd_o  (tab_rd)
   );

   clut_out #(
      .IDX_W(IDX_W),
      .CH_W (CH_W),
      .NCH  (NCH)
   ) i_out (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (src_sel),
      .pix_idx_i(pix_idx_i),
      .tab_i    (tab_rd),
      .colour_o (colour_o)
   );

endmodule

// File: rtl/clut_pix_path_chk.sv
module clut_pix_path_chk
   import clut_pkg::*;
#(
   parameter int unsigned IDX_W     = 8,
   parameter int unsigned OVL_W     = 5,
   parameter int unsigned OVL_COUNT = 30,
   parameter int unsigned CH_W      = 8,
   parameter int unsigned NCH       = 3
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic [IDX_W-1:0]    pix_idx_i,
   input logic [OVL_W-1:0]    ovl_code_i,
   input logic                clut_keep_i,
   input logic                fmt_bypass_en_i,
   input logic                wr_en_i,
   input logic [IDX_W-1:0]    wr_addr_i,
   input logic [CH_W*NCH-1:0] wr_data_i,
   input logic [IDX_W-1:0]    rd_addr,
   input clut_src_e           src_sel,
   input logic [CH_W*NCH-1:0] colour_o
);

   localparam int unsigned DEPTH = 1 << IDX_W;
   localparam int unsigned BASE  = DEPTH - OVL_COUNT;

   logic code_valid;
   assign code_valid = (ovl_code_i != '0) && (ovl_code_i <= OVL_W'(OVL_COUNT));

   // R3: a valid code addresses its reserved slot
   assert_ovl_slot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      code_valid |-> (int'(rd_addr) == int'(BASE) + int'(ovl_code_i) - 1));

   // R2 / R4: without an overlay the pixel itself is looked up
   assert_pixel_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !code_valid |-> (rd_addr == pix_idx_i));

   // R8: an overlay never leaves the bypass route selected
   assert_ovl_priority_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      code_valid |-> (src_sel == SRC_TABLE));

   // R5: bypass copies the pixel onto every channel one clock later
   assert_bypass_copy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fmt_bypass_en_i && !clut_keep_i && !code_valid)
      |=> (colour_o == {NCH{CH_W'({$past(pix_idx_i), {(CH_W-IDX_W){1'b0}}})}}));

   // R6: enable low keeps the table path
   assert_enable_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fmt_bypass_en_i |-> (src_sel == SRC_TABLE));

   // R10: same-cycle write to the read address is forwarded
   assert_write_through_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && (wr_addr_i == rd_addr) && (src_sel == SRC_TABLE))
      |=> (colour_o == $past(wr_data_i)));

endmodule

bind clut_pix_path clut_pix_path_chk #(
   .IDX_W    (IDX_W),
   .OVL_W    (OVL_W),
   .OVL_COUNT(OVL_COUNT),
   .CH_W     (CH_W),
   .NCH      (NCH)
) u_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .pix_idx_i      (pix_idx_i),
   .ovl_code_i     (ovl_code_i),
   .clut_keep_i    (clut_keep_i),
   .fmt_bypass_en_i(fmt_bypass_en_i),
   .wr_en_i        (wr_en_i),
   .wr_addr_i      (wr_addr_i),
   .wr_data_i      (wr_data_i),
   .rd_addr        (rd_addr),
   .src_sel        (src_sel),
   .colour_o       (colour_o)
);

// File: tb/test_clut_pix_path.sv
`timescale 1ns/1ps
module test_clut_pix_path;

   localparam int IDX_W = 8;
   localparam int OVL_W = 5;
   localparam int OVL_N = 30;
   localparam int CH_W  = 8;
   localparam int NCH   = 3;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  pix;
   logic [4:0]  code;
   logic        keep;
   logic        byp_en;
   logic        wen;
   logic [7:0]  waddr;
   logic [23:0] wdata;
   logic [23:0] colour;

   int checks = 0;
   int errors = 0;
   logic [23:0] tab [256];

   always #2.5 clk = ~clk;

   clut_pix_path #(
      .IDX_W(IDX_W), .OVL_W(OVL_W), .OVL_COUNT(OVL_N),
      .CH_W(CH_W), .NCH(NCH), .WRITE_THROUGH(1'b1)
   ) i_clut_pix_path (
      .clk_i(clk), .rst_ni(rst_n), .pix_idx_i(pix), .ovl_code_i(code),
      .clut_keep_i(keep), .fmt_bypass_en_i(byp_en), .wr_en_i(wen),
      .wr_addr_i(waddr), .wr_data_i(wdata), .colour_o(colour)
   );

   function automatic logic [23:0] pattern(input int i);
      logic [7:0] v;
      v = 8'(i);
      return {8'(v * 8'd7 + 8'd1), ~v, v ^ 8'hA5};
   endfunction

   task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // drive at falling edge, step one rising edge, sample after it
   task automatic step(input logic [7:0] p, input logic [4:0] c, input logic k, input logic e);
      @(negedge clk);
      pix = p; code = c; keep = k; byp_en = e;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; pix = '0; code = '0; keep = 1'b1; byp_en = 1'b0;
      wen = 1'b0; waddr = '0; wdata = '0;
      repeat (3) @(posedge clk);
      #1 check("R1 during reset", colour, 24'h0);
      @(negedge clk) rst_n = 1'b1;
      check("R1 after release", colour, 24'h0);
   endtask

   task automatic t_load();
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         wen = 1'b1; waddr = 8'(i); wdata = pattern(i); tab[i] = pattern(i);
      end
      @(negedge clk) wen = 1'b0;
   endtask

   task automatic t_normal();
      int idx [4] = '{0, 17, 200, 225};
      foreach (idx[n]) begin
         step(8'(idx[n]), 5'd0, 1'b1, 1'b0);
         check("R2 table lookup", colour, tab[idx[n]]);
      end
   endtask

   task automatic t_overlay();
      step(8'd9, 5'd1, 1'b1, 1'b0);
      check("R3 code 1 -> 226", colour, tab[226]);
      step(8'd77, 5'd30, 1'b1, 1'b0);
      check("R3 code 30 -> 255", colour, tab[255]);
      step(8'd3, 5'd12, 1'b1, 1'b0);
      check("R3 code 12 -> 237", colour, tab[237]);
   endtask

   task automatic t_no_overlay();
      step(8'd50, 5'd31, 1'b1, 1'b0);
      check("R4 code 31 is none", colour, tab[50]);
      step(8'd51, 5'd0, 1'b1, 1'b0);
      check("R4 code 0 is none", colour, tab[51]);
   endtask

   task automatic t_bypass();
      step(8'h3C, 5'd0, 1'b0, 1'b1);
      check("R5 bypass replica", colour, {3{8'h3C}});
      step(8'hF0, 5'd31, 1'b0, 1'b1);
      check("R5 bypass with code 31", colour, {3{8'hF0}});
   endtask

   task automatic t_enable_off();
      step(8'h3C, 5'd0, 1'b0, 1'b0);
      check("R6 keep pin ignored", colour, tab[8'h3C]);
   endtask

   task automatic t_keep_high();
      step(8'h81, 5'd0, 1'b1, 1'b1);
      check("R7 keep high uses table", colour, tab[8'h81]);
   endtask

   task automatic t_priority();
      step(8'h22, 5'd5, 1'b0, 1'b1);
      check("R8 overlay beats bypass", colour, tab[230]);
   endtask

   task automatic t_write_readback();
      @(negedge clk);
      wen = 1'b1; waddr = 8'd100; wdata = 24'hC0FFEE; tab[100] = 24'hC0FFEE;
      pix = 8'd1; code = '0; keep = 1'b1; byp_en = 1'b0;
      @(negedge clk) wen = 1'b0;
      step(8'd100, 5'd0, 1'b1, 1'b0);
      check("R9 write then read", colour, 24'hC0FFEE);
   endtask

   task automatic t_write_through();
      @(negedge clk);
      pix = 8'd40; code = '0; keep = 1'b1; byp_en = 1'b0;
      wen = 1'b1; waddr = 8'd40; wdata = 24'h123456; tab[40] = 24'h123456;
      @(posedge clk);
      #1 check("R10 same-cycle forward", colour, 24'h123456);
      @(negedge clk) wen = 1'b0;
      @(negedge clk);
      pix = 8'd240; code = 5'd15; wen = 1'b1; waddr = 8'd240;
      wdata = 24'hABCDEF; tab[240] = 24'hABCDEF;
      @(posedge clk);
      #1 check("R10 forward on overlay slot", colour, 24'hABCDEF);
      @(negedge clk) wen = 1'b0;
   endtask

   task automatic t_latency();
      logic [23:0] prev;
      step(8'd10, 5'd0, 1'b1, 1'b0);
      prev = tab[10];
      @(negedge clk);
      pix = 8'h66; keep = 1'b0; byp_en = 1'b1;
      #1 check("R11 no change before edge", colour, prev);
      @(posedge clk);
      #1 check("R11 bypass after one edge", colour, {3{8'h66}});
      @(negedge clk);
      code = 5'd2;
      #1 check("R11 held until edge", colour, {3{8'h66}});
      @(posedge clk);
      #1 check("R11 overlay after one edge", colour, tab[227]);
   endtask

   initial begin
      t_reset();
      t_load();
      t_normal();
      t_overlay();
      t_no_overlay();
      t_bypass();
      t_enable_off();
      t_keep_high();
      t_priority();
      t_write_readback();
      t_write_through();
      t_latency();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule